// File: doc/BRIEF.md
# Stereo Mono-Mix Output Router

This block sits behind a pair of ADC channels. It takes a signed left sample word and a signed right sample word, each qualified by one shared sample strobe. It presents a registered left and right output word. A 2-bit mixing-mode input and a 1-bit mono-output select decide what each output carries.

Three modes are supported:
- **Stereo**: each channel passes straight through.
- **Digital mono-mix**: the average of both channels is sent to both outputs.
- **Analogue mono-mix routing**: the right output carries either its own ADC word or a copy of the left word.

The fourth mode code is reserved and is treated as stereo. Configuration is sampled only together with a strobe, so a sample is never produced under a mix of two settings. The outputs hold their last value until the next strobe.

Top module: `mono_mix_router`

## Requirements
- R1: With mode 2'b00 (stereo) at a strobe, in the next cycle left output equals left input and right output equals right input.
- R2: With mode 2'b10 (digital mix) at a strobe, in the next cycle both outputs equal (L+R) shifted right by one bit arithmetically, computed one bit wider than the inputs. The result rounds toward minus infinity.
- R3: With mode 2'b01 (analogue routing) and select 0 at a strobe, each output carries its own input channel in the next cycle.
- R4: With mode 2'b01 and select 1 at a strobe, both outputs carry the left input in the next cycle.
- R5: Mode 2'b11 (reserved) behaves exactly as stereo, whatever the select.
- R6: In stereo mode the select has no effect on either output.
- R7: The output valid flag is high in exactly the cycle after each cycle with the input strobe high, and low otherwise.
- R8: Between strobes both outputs hold their value, even when the input words, the mode or the select change.
- R9: After reset both output words are zero and the output valid flag is low.
- R10: The mix never overflows: full-scale positive pairs give full-scale positive, and full-scale negative pairs give full-scale negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe for both input words |
| adc_l_i | input | DATA_W | Left ADC sample, signed |
| adc_r_i | input | DATA_W | Right ADC sample, signed |
| mix_mode_i | input | 2 | 00 stereo, 01 analogue routing, 10 digital mix, 11 reserved |
| mono_sel_i | input | 1 | In analogue routing, 1 copies left onto right |
| out_valid_o | output | 1 | Output words updated this cycle |
| out_l_o | output | DATA_W | Left output word |
| out_r_o | output | DATA_W | Right output word |

## Verification
The hardest conditions to reach from the ports are two. The first is a configuration change that lands between strobes: it must leave the held outputs untouched. The second is the rounding of the average at the signed extremes. The stimulus inserts random idle gaps and rewrites mode, select and data during those gaps. It then checks that the outputs did not move. Directed samples pair full-scale values and odd sums of mixed sign, which exercise the floor rounding and the headroom bit.

// File: rtl/mix_pkg.sv
package mix_pkg;
  typedef enum logic [1:0] {
    MODE_STEREO = 2'b00,
    MODE_AROUTE = 2'b01,
    MODE_DMIX   = 2'b10,
    MODE_RSVD   = 2'b11
  } mix_mode_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_L   = 0;
  localparam int unsigned CH_R   = 1;
endpackage

// File: rtl/mix_avg.sv
module mix_avg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] avg_o
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] half;

  always_comb begin
    sum  = SUM_W'(a_i) + SUM_W'(b_i);
    half = sum >>> 1;
    avg_o = half[DATA_W-1:0];
  end
endmodule

// File: rtl/mix_route.sv
module mix_route
  import mix_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  mix_mode_e                mode_i,
  input  logic                     sel_i,
  input  logic signed [DATA_W-1:0] l_i,
  input  logic signed [DATA_W-1:0] r_i,
  input  logic signed [DATA_W-1:0] avg_i,
  output logic signed [DATA_W-1:0] ch_o [NUM_CH]
);
  always_comb begin
    ch_o[CH_L] = l_i;
    ch_o[CH_R] = r_i;
    unique case (mode_i)
      MODE_DMIX: begin
        ch_o[CH_L] = avg_i;
        ch_o[CH_R] = avg_i;
      end
      MODE_AROUTE: begin
        if (sel_i) ch_o[CH_R] = l_i;
      end
      // reserved decodes as stereo; select ignored
      MODE_STEREO, MODE_RSVD: ;
      default: ;
    endcase
  end
endmodule

// File: rtl/mono_mix_router.sv
module mono_mix_router
  import mix_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic signed [DATA_W-1:0] adc_l_i,
  input  logic signed [DATA_W-1:0] adc_r_i,
  input  logic [1:0]               mix_mode_i,
  input  logic                     mono_sel_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_l_o,
  output logic signed [DATA_W-1:0] out_r_o
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  mix_mode_e                mode;
  logic signed [DATA_W-1:0] avg;
  logic signed [DATA_W-1:0] routed [NUM_CH];
  logic signed [DATA_W-1:0] out_q  [NUM_CH];
  logic                     vld_q;

  assign mode = mix_mode_e'(mix_mode_i);

  mix_avg #(.DATA_W(DATA_W)) u_avg (
    .a_i  (adc_l_i),
    .b_i  (adc_r_i),
    .avg_o(avg)
  );

  mix_route #(.DATA_W(DATA_W)) u_route (
    .mode_i(mode),
    .sel_i (mono_sel_i),
    .l_i   (adc_l_i),
    .r_i   (adc_r_i),
    .avg_i (avg),
    .ch_o  (routed)
  );

  // config is only consumed with a strobe: sample boundary
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          out_q[c] <= '0;
      else if (smp_valid_i) out_q[c] <= routed[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= smp_valid_i;
  end

  assign out_valid_o = vld_q;
  assign out_l_o     = out_q[CH_L];
  assign out_r_o     = out_q[CH_R];

  // R1
  stereo_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mix_mode_i == 2'b00) |=>
      (out_l_o == $past(adc_l_i) && out_r_o == $past(adc_r_i)));

  // R2
  dmix_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mix_mode_i == 2'b10) |=> (out_l_o == out_r_o));

  // R4
  aroute_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mix_mode_i == 2'b01 && mono_sel_i) |=>
      (out_l_o == $past(adc_l_i) && out_r_o == $past(adc_l_i)));

  // R5
  rsvd_stereo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mix_mode_i == 2'b11) |=>
      (out_r_o == $past(adc_r_i)));

  // R7
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> out_valid_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(out_l_o) && $stable(out_r_o) && !out_valid_o));

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mix_mode_i == 2'b10 && adc_l_i == MAX_V && adc_r_i == MAX_V)
      |=> (out_l_o == MAX_V));
  // R10
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mix_mode_i == 2'b10 && adc_l_i == MIN_V && adc_r_i == MIN_V)
      |=> (out_l_o == MIN_V));
endmodule

// File: tb/mono_mix_router_bench.sv
module mono_mix_router_bench;
  localparam int W = 16;
  localparam logic signed [W-1:0] MAXV = 16'sh7FFF;
  localparam logic signed [W-1:0] MINV = -16'sh8000;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0, sel = 1'b0;
  logic signed [W-1:0] l_in = '0, r_in = '0;
  logic [1:0] mode = 2'b00;
  logic ov;
  logic signed [W-1:0] ol, orr;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mono_mix_router #(.DATA_W(W)) u_mono_mix_router (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vld), .adc_l_i(l_in), .adc_r_i(r_in),
    .mix_mode_i(mode), .mono_sel_i(sel), .out_valid_o(ov), .out_l_o(ol), .out_r_o(orr)
  );

  function automatic logic signed [W-1:0] avg_f(logic signed [W-1:0] a, logic signed [W-1:0] b);
    logic signed [W:0] s;
    s = (W+1)'(a) + (W+1)'(b);
    s = s >>> 1;
    return s[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] exp_l(logic [1:0] m, logic signed [W-1:0] a, logic signed [W-1:0] b);
    return (m == 2'b10) ? avg_f(a, b) : a;
  endfunction

  function automatic logic signed [W-1:0] exp_r(logic [1:0] m, logic s, logic signed [W-1:0] a, logic signed [W-1:0] b);
    if (m == 2'b10) return avg_f(a, b);
    if (m == 2'b01 && s) return a;
    return b;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [1:0] m, logic s);
    case (m)
      2'b00: return s ? "R6" : "R1";
      2'b01: return s ? "R4" : "R3";
      2'b10: return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic send(logic [1:0] m, logic s, logic signed [W-1:0] a, logic signed [W-1:0] b);
    @(negedge clk);
    mode = m; sel = s; l_in = a; r_in = b; vld = 1'b1;
    @(posedge clk); #1;
    chk(req_of(m, s), ol, exp_l(m, a, b));
    chk(req_of(m, s), orr, exp_r(m, s, a, b));
    chk("R7", {15'd0, ov}, 16'd1);
    @(negedge clk); vld = 1'b0;
  endtask

  // idle cycles with config/data churn; outputs must hold
  task automatic idle(int n);
    logic signed [W-1:0] hl, hr;
    hl = ol; hr = orr;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mode = 2'($urandom); sel = 1'($urandom);
      l_in = W'($urandom); r_in = W'($urandom);
      @(posedge clk); #1;
      chk("R8", ol, hl);
      chk("R8", orr, hr);
      chk("R7", {15'd0, ov}, 16'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #23;
    chk("R9", ol, '0);
    chk("R9", orr, '0);
    chk("R9", {15'd0, ov}, '0);
    rst_n = 1'b1;
    // directed corners
    send(2'b00, 1'b0, 16'sh1234, -16'sh0567);
    send(2'b00, 1'b1, 16'sh0101, 16'sh0202); // R6
    send(2'b01, 1'b0, 16'sh0AAA, 16'sh0BBB);
    send(2'b01, 1'b1, 16'sh0AAA, 16'sh0BBB);
    send(2'b11, 1'b1, 16'sh0003, -16'sh0004); // R5
    send(2'b11, 1'b0, MAXV, MINV);
    send(2'b10, 1'b0, MAXV, MAXV);            // R10
    chk("R10", ol, MAXV);
    send(2'b10, 1'b1, MINV, MINV);            // R10
    chk("R10", orr, MINV);
    send(2'b10, 1'b0, 16'sh0000, -16'sh0001); // floor: -1
    chk("R2", ol, -16'sh0001);
    send(2'b10, 1'b0, 16'sh0003, 16'sh0000);  // 1
    chk("R2", ol, 16'sh0001);
    send(2'b10, 1'b0, MAXV, MINV);            // -1
    chk("R2", ol, -16'sh0001);
    idle(3);
    // random
    for (int k = 0; k < 400; k++) begin
      send(2'($urandom), 1'($urandom), W'($urandom), W'($urandom));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 4));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule